// File: doc/BRIEF.md
# Two-Phase Neighbour-Linked Lookup Cell Array

This block is a rectangular array of identical logic cells with no routing fabric between them. Each cell has four one-bit inputs, one from each adjacent cell (or from a boundary pin at the array edge). It drives four one-bit outputs, one toward each neighbour. Every output bit comes from its own 16-entry lookup table, which the four inputs index. Each cell therefore holds 64 configuration bits. All cell outputs are registered. A signal moves across the array only by passing from cell to cell.

Cells are split in a checkerboard. Cells with an even row+column sum form phase A, and cells with an odd sum form phase B. Each accepted step updates one phase, and the other phase holds its registers steady. Every neighbour of a cell belongs to the opposite phase, so no cell reads a value that is changing in the same step. The price is one cell of latency per phase step.

Configuration enters through one serial chain that runs through every cell. While the chain is shifting, the array does not step. Boundary inputs come from per-edge input ports. The outward-facing outputs of the edge cells appear on per-edge output ports.

Top module: `lut_grid`

## Requirements
- R1: While rst_n is low, every cell output register is 0, so all edge outputs read 0. phase_o reads 0, which means phase A is next.
- R2: While cfg_en is high, each clock shifts cfg_din one position into a chain of 64*ROWS*COLS bits. The cells are linked in order r*COLS+c. A bit enters at bit 63 of cell 0 and moves toward bit 0, then on into the next cell. cfg_dout is bit 0 of the last cell. The first bit sent after a full load ends in bit 0 of the last cell.
- R3: While cfg_en is high, no cell output changes and phase_o holds, even if step_en is high.
- R4: The directions are numbered N=0, E=1, S=2, W=3. The table index is {W,S,E,N} with N as the LSB. On update, output k takes configuration bit k*16+index.
- R5: A step with phase_o=0 updates only the cells where (row+col) is even. A step with phase_o=1 updates only the cells where it is odd. Row 0 is the north edge and column 0 is the west edge.
- R6: A step is step_en high with cfg_en low. Each step inverts phase_o. With step_en low, the outputs and phase_o hold.
- R7: Output k of a cell feeds input (k+2) mod 4 of its neighbour in direction k. At an edge, the missing neighbour's value comes from edge_*_i, indexed by column (north/south) or by row (east/west). edge_*_o exposes the edge cells' outputs that face outward.
- R8: In a chain of N pass-through cells that starts at a phase-A cell, a bit applied at the boundary reaches the far edge output in exactly N steps after reset, and not in N-1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset of cell outputs and phase |
| cfg_en | input | 1 | Shift configuration chain; suppresses steps |
| cfg_din | input | 1 | Serial configuration data in |
| cfg_dout | output | 1 | Serial configuration data out (end of chain) |
| step_en | input | 1 | Request one phase step this clock |
| phase_o | output | 1 | Phase updated by the next step (0 = A, 1 = B) |
| edge_n_i | input | COLS | North boundary inputs, per column |
| edge_e_i | input | ROWS | East boundary inputs, per row |
| edge_s_i | input | COLS | South boundary inputs, per column |
| edge_w_i | input | ROWS | West boundary inputs, per row |
| edge_n_o | output | COLS | North-facing outputs of row 0 |
| edge_e_o | output | ROWS | East-facing outputs of the last column |
| edge_s_o | output | COLS | South-facing outputs of the last row |
| edge_w_o | output | ROWS | West-facing outputs of column 0 |

## Verification
A cell register that updates in the wrong phase shows up on the first step as a wrong checkerboard pattern on the north and west edge outputs. A mis-wired neighbour, or a wrong table index order, shows up at the far edge when a pass-through chain is run. There the bit arrives a step early, a step late, or never. A corrupted configuration chain shows up on cfg_dout on the very clock that follows a full load.

// File: rtl/lut_grid_pkg.sv
package lut_grid_pkg;
   localparam int NUM_DIRS  = 4;
   localparam int TBL_DEPTH = 16;
   localparam int CFG_BITS  = NUM_DIRS * TBL_DEPTH;

   localparam int DIR_N = 0;
   localparam int DIR_E = 1;
   localparam int DIR_S = 2;
   localparam int DIR_W = 3;

   typedef logic [NUM_DIRS-1:0] nbr_vec_t;
   typedef logic [CFG_BITS-1:0] cell_cfg_t;

   function automatic int opposite(input int dir);
      return (dir + 2) % NUM_DIRS;
   endfunction

   function automatic bit cell_parity(input int row, input int col);
      return bit'((row + col) % 2);
   endfunction
endpackage

// File: rtl/lut_cell.sv
module lut_cell
   import lut_grid_pkg::*;
(
   input  logic     clk,
   input  logic     rst_n,
   input  logic     shift_en,
   input  logic     sin,
   output logic     sout,
   input  logic     upd,
   input  nbr_vec_t nbr_i,
   output nbr_vec_t out_o
);
   cell_cfg_t cfg_q;
   nbr_vec_t  nxt;
   nbr_vec_t  out_q;

   // configuration storage shifts toward bit 0; no reset on the chain
   always_ff @(posedge clk) begin
      if (shift_en) cfg_q <= {sin, cfg_q[CFG_BITS-1:1]};
   end
   assign sout = cfg_q[0];

   // one table per output direction, indexed by {W,S,E,N}
   for (genvar k = 0; k < NUM_DIRS; k++) begin : g_tbl
      localparam logic [1:0] KSEL = k[1:0];
      assign nxt[k] = cfg_q[{KSEL, nbr_i}];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   out_q <= '0;
      else if (upd) out_q <= nxt;
   end
   assign out_o = out_q;
endmodule

// File: rtl/lut_phase_ctrl.sv
module lut_phase_ctrl (
   input  logic clk,
   input  logic rst_n,
   input  logic step_en,
   input  logic cfg_en,
   output logic phase_o,
   output logic upd_a,
   output logic upd_b
);
   logic phase_q;
   logic go;

   assign go = step_en & ~cfg_en;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  phase_q <= 1'b0;
      else if (go) phase_q <= ~phase_q;
   end

   assign upd_a   = go & ~phase_q;
   assign upd_b   = go &  phase_q;
   assign phase_o = phase_q;
endmodule

// File: rtl/lut_grid.sv
module lut_grid
   import lut_grid_pkg::*;
#(
   parameter int ROWS = 4,
   parameter int COLS = 6
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            cfg_en,
   input  logic            cfg_din,
   output logic            cfg_dout,
   input  logic            step_en,
   output logic            phase_o,
   input  logic [COLS-1:0] edge_n_i,
   input  logic [ROWS-1:0] edge_e_i,
   input  logic [COLS-1:0] edge_s_i,
   input  logic [ROWS-1:0] edge_w_i,
   output logic [COLS-1:0] edge_n_o,
   output logic [ROWS-1:0] edge_e_o,
   output logic [COLS-1:0] edge_s_o,
   output logic [ROWS-1:0] edge_w_o
);
   localparam int NCELL = ROWS * COLS;
   localparam int QW    = NCELL * NUM_DIRS;

   if (ROWS < 2) begin : g_chk_rows
      $error("lut_grid: ROWS must be at least 2");
   end
   if (COLS < 2) begin : g_chk_cols
      $error("lut_grid: COLS must be at least 2");
   end

   logic [QW-1:0]  cell_q;
   logic [NCELL:0] chn;
   logic           upd_a;
   logic           upd_b;

   lut_phase_ctrl u_phase (
      .clk     (clk),
      .rst_n   (rst_n),
      .step_en (step_en),
      .cfg_en  (cfg_en),
      .phase_o (phase_o),
      .upd_a   (upd_a),
      .upd_b   (upd_b)
   );

   assign chn[0]   = cfg_din;
   assign cfg_dout = chn[NCELL];

   for (genvar r = 0; r < ROWS; r++) begin : g_row
      for (genvar c = 0; c < COLS; c++) begin : g_col
         localparam int ID = r * COLS + c;
         nbr_vec_t nbr;
         nbr_vec_t q;
         logic     upd;

         if (cell_parity(r, c) == 1'b0) begin : g_pa
            assign upd = upd_a;
         end else begin : g_pb
            assign upd = upd_b;
         end

         if (r == 0) begin : g_n_edge
            assign nbr[DIR_N] = edge_n_i[c];
         end else begin : g_n_cell
            assign nbr[DIR_N] = cell_q[((r-1)*COLS + c)*NUM_DIRS + opposite(DIR_N)];
         end

         if (c == COLS-1) begin : g_e_edge
            assign nbr[DIR_E] = edge_e_i[r];
         end else begin : g_e_cell
            assign nbr[DIR_E] = cell_q[(r*COLS + c + 1)*NUM_DIRS + opposite(DIR_E)];
         end

         if (r == ROWS-1) begin : g_s_edge
            assign nbr[DIR_S] = edge_s_i[c];
         end else begin : g_s_cell
            assign nbr[DIR_S] = cell_q[((r+1)*COLS + c)*NUM_DIRS + opposite(DIR_S)];
         end

         if (c == 0) begin : g_w_edge
            assign nbr[DIR_W] = edge_w_i[r];
         end else begin : g_w_cell
            assign nbr[DIR_W] = cell_q[(r*COLS + c - 1)*NUM_DIRS + opposite(DIR_W)];
         end

         lut_cell u_cell (
            .clk      (clk),
            .rst_n    (rst_n),
            .shift_en (cfg_en),
            .sin      (chn[ID]),
            .sout     (chn[ID+1]),
            .upd      (upd),
            .nbr_i    (nbr),
            .out_o    (q)
         );

         assign cell_q[ID*NUM_DIRS +: NUM_DIRS] = q;
      end
   end

   for (genvar c = 0; c < COLS; c++) begin : g_ns_out
      assign edge_n_o[c] = cell_q[c*NUM_DIRS + DIR_N];
      assign edge_s_o[c] = cell_q[((ROWS-1)*COLS + c)*NUM_DIRS + DIR_S];
   end
   for (genvar r = 0; r < ROWS; r++) begin : g_ew_out
      assign edge_e_o[r] = cell_q[(r*COLS + COLS-1)*NUM_DIRS + DIR_E];
      assign edge_w_o[r] = cell_q[(r*COLS)*NUM_DIRS + DIR_W];
   end
endmodule

// File: rtl/lut_grid_chk.sv
module lut_grid_chk #(
   parameter int ROWS = 4,
   parameter int COLS = 6
) (
   input logic                   clk,
   input logic                   rst_n,
   input logic                   cfg_en,
   input logic                   step_en,
   input logic                   phase_o,
   input logic [ROWS*COLS*4-1:0] cell_q
);
   localparam int QW = ROWS * COLS * 4;

   function automatic logic [QW-1:0] par_mask(input bit par);
      logic [QW-1:0] m;
      m = '0;
      for (int r = 0; r < ROWS; r++)
         for (int c = 0; c < COLS; c++)
            if (bit'((r + c) % 2) == par) m[(r*COLS + c)*4 +: 4] = 4'hF;
      return m;
   endfunction

   localparam logic [QW-1:0] MASK_A = par_mask(1'b0);
   localparam logic [QW-1:0] MASK_B = par_mask(1'b1);

   a_r3_cfg_freeze: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_en |=> ($stable(cell_q) && $stable(phase_o)));

   a_r6_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !step_en |=> ($stable(cell_q) && $stable(phase_o)));

   a_r6_phase_flip: assert property (@(posedge clk) disable iff (!rst_n)
      (step_en && !cfg_en) |=> (phase_o != $past(phase_o)));

   a_r5_b_holds_in_a: assert property (@(posedge clk) disable iff (!rst_n)
      (step_en && !cfg_en && !phase_o) |=> $stable(cell_q & MASK_B));

   a_r5_a_holds_in_b: assert property (@(posedge clk) disable iff (!rst_n)
      (step_en && !cfg_en && phase_o) |=> $stable(cell_q & MASK_A));
endmodule

bind lut_grid lut_grid_chk #(.ROWS(ROWS), .COLS(COLS)) chk_i (
   .clk     (clk),
   .rst_n   (rst_n),
   .cfg_en  (cfg_en),
   .step_en (step_en),
   .phase_o (phase_o),
   .cell_q  (cell_q)
);

// File: tb/lut_grid_tb_top.sv
module lut_grid_tb_top;
   localparam int ROWS  = 4;
   localparam int COLS  = 6;
   localparam int NCELL = ROWS * COLS;

   localparam logic [63:0] CFG_PASS_E = 64'h0000_0000_FF00_0000; // out E = in W
   localparam logic [63:0] CFG_PASS_S = 64'h0000_AAAA_0000_0000; // out S = in N
   localparam logic [63:0] CFG_ONES   = 64'hFFFF_FFFF_FFFF_FFFF;

   logic            clk = 1'b0;
   logic            rst_n = 1'b0;
   logic            cfg_en = 1'b0;
   logic            cfg_din = 1'b0;
   logic            cfg_dout;
   logic            step_en = 1'b0;
   logic            phase_o;
   logic [COLS-1:0] edge_n_i = '0;
   logic [ROWS-1:0] edge_e_i = '0;
   logic [COLS-1:0] edge_s_i = '0;
   logic [ROWS-1:0] edge_w_i = '0;
   logic [COLS-1:0] edge_n_o;
   logic [ROWS-1:0] edge_e_o;
   logic [COLS-1:0] edge_s_o;
   logic [ROWS-1:0] edge_w_o;

   int n_checks = 0;
   int n_errors = 0;
   bit done = 1'b0;

   always #2 clk = ~clk;

   lut_grid #(.ROWS(ROWS), .COLS(COLS)) dut_i (
      .clk(clk), .rst_n(rst_n), .cfg_en(cfg_en), .cfg_din(cfg_din),
      .cfg_dout(cfg_dout), .step_en(step_en), .phase_o(phase_o),
      .edge_n_i(edge_n_i), .edge_e_i(edge_e_i), .edge_s_i(edge_s_i),
      .edge_w_i(edge_w_i), .edge_n_o(edge_n_o), .edge_e_o(edge_e_o),
      .edge_s_o(edge_s_o), .edge_w_o(edge_w_o)
   );

   task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_errors++;
         $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic tick();
      @(negedge clk);
   endtask

   task automatic do_reset();
      rst_n = 1'b0;
      tick(); tick();
      rst_n = 1'b1;
      tick();
   endtask

   // first bit sent lands in bit 0 of the last cell
   task automatic load_all(input logic [63:0] img);
      cfg_en = 1'b1;
      for (int i = NCELL-1; i >= 0; i--)
         for (int b = 0; b < 64; b++) begin
            cfg_din = img[b];
            tick();
         end
      cfg_en = 1'b0;
      cfg_din = 1'b0;
   endtask

   task automatic step();
      step_en = 1'b1;
      tick();
      step_en = 1'b0;
   endtask

   task automatic t_reset();
      do_reset();
      check("R1 edge_n_o", 64'(edge_n_o), 64'd0);
      check("R1 edge_e_o", 64'(edge_e_o), 64'd0);
      check("R1 edge_s_o", 64'(edge_s_o), 64'd0);
      check("R1 edge_w_o", 64'(edge_w_o), 64'd0);
      check("R1 phase_o", 64'(phase_o), 64'd0);
   endtask

   task automatic t_cfg_chain();
      load_all(64'h0123_4567_89AB_CDEF);
      check("R2 cfg_dout bit0 of last cell", 64'(cfg_dout), 64'd1);
      cfg_en = 1'b1; cfg_din = 1'b0;
      tick();
      check("R2 cfg_dout bit1 of last cell", 64'(cfg_dout), 64'd1);
      tick(); tick(); tick();
      check("R2 cfg_dout bit4 of last cell", 64'(cfg_dout), 64'd0);
      cfg_en = 1'b0;
   endtask

   task automatic t_cfg_freeze();
      load_all(CFG_ONES);
      do_reset();
      cfg_en = 1'b1; cfg_din = 1'b1; step_en = 1'b1;
      tick();
      step_en = 1'b0; cfg_en = 1'b0;
      check("R3 no update under cfg_en", 64'(edge_n_o), 64'd0);
      check("R3 phase held under cfg_en", 64'(phase_o), 64'd0);
      tick(); tick();
      check("R6 idle holds outputs", 64'(edge_w_o), 64'd0);
   endtask

   task automatic t_checkerboard();
      logic [COLS-1:0] exp_n;
      logic [ROWS-1:0] exp_w;
      load_all(CFG_ONES);
      do_reset();
      for (int c = 0; c < COLS; c++) exp_n[c] = ~c[0];
      for (int r = 0; r < ROWS; r++) exp_w[r] = ~r[0];
      step();
      check("R5 phase A north row", 64'(edge_n_o), 64'(exp_n));
      check("R5 phase A west col", 64'(edge_w_o), 64'(exp_w));
      check("R6 phase flips to B", 64'(phase_o), 64'd1);
      step();
      check("R5 phase B fills north row", 64'(edge_n_o), 64'({COLS{1'b1}}));
      check("R4 all-ones table east col", 64'(edge_e_o), 64'({ROWS{1'b1}}));
      check("R6 phase back to A", 64'(phase_o), 64'd0);
   endtask

   task automatic t_east_chain();
      load_all(CFG_PASS_E);
      do_reset();
      edge_w_i = '1;
      for (int k = 1; k <= COLS; k++) begin
         step();
         check("R8 r7_ east arrival", 64'(edge_e_o[0]), 64'(k >= COLS));
      end
      check("R4 E table ignores N input", 64'(edge_n_o), 64'd0);
      edge_w_i = '0;
   endtask

   task automatic t_south_chain();
      load_all(CFG_PASS_S);
      do_reset();
      edge_n_i = '1;
      for (int k = 1; k <= ROWS; k++) begin
         step();
         check("R8 r7_ south arrival", 64'(edge_s_o[0]), 64'(k >= ROWS));
      end
      edge_n_i = '0;
   endtask

   initial begin
      tick();
      t_reset();
      t_cfg_chain();
      t_cfg_freeze();
      t_checkerboard();
      t_east_chain();
      t_south_chain();
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         n_checks++;
         n_errors++;
         $display("FAIL watchdog: actual=timeout expected=completion");
         $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
         $finish;
      end
   end
endmodule